// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block sits beside a single-data-rate synchronous DRAM command bus and follows the power state of the memory from the clock-enable level and the command pins on every clock edge. It compares the clock-enable level on the current edge with the level on the edge before. From that pair, the decoded command and a bank-status code from the controller, it works out the next state. The states are idle, row active, access in progress, self refresh, self-refresh recovery, power down and clock suspend.

Each edge may carry a combination the memory does not accept, or one whose previous clock-enable level is impossible for the current state. The block reports these through two single-cycle flags. It also emits a one-cycle pulse for every auto refresh it sees.

The wait after leaving self refresh is a row-cycle count taken from an input port when recovery begins. Only edges with the clock enable high advance it. Command decoding for reads, writes and precharge, and the data path, belong elsewhere.

Top module: `sdram_pwr_tracker`

## Requirements
- R1: A synchronous active-high reset sets the state to idle and clears all three flags. It also records the previous clock enable as high. The state codes on `state_o` are: 0 idle, 1 row active, 2 access in progress, 3 self refresh, 4 self-refresh recovery, 5 power down, 6 clock suspend.
- R2: In idle, row active or access, an edge that is not a high-to-low clock-enable transition selects the state from `bank_st`: 0 all banks idle → idle, 1 row open → row active, 2 or 3 burst in progress → access.
- R3: An edge with clock enable high now and before, `bank_st` 0, and command {cs_n,ras_n,cas_n,we_n} = 0001 raises `refresh_o` for exactly the next cycle. No other edge raises it.
- R4: In idle, row active or access, a high-to-low clock-enable edge with `bank_st` 0 and command 0001 enters self refresh (code 3). Self refresh is entered from no other bank status.
- R5: A high-to-low clock-enable edge enters power down (code 5) in two cases: `bank_st` 0 with any command other than 0001, or `bank_st` 1 with any command.
- R6: A high-to-low clock-enable edge with `bank_st` 2 or 3 enters clock suspend. Clock enable low keeps clock suspend. A low-to-high edge leaves it for the state that R2 selects.
- R7: In self refresh with previous clock enable low, current clock enable low holds the state. A rise with deselect (cs_n=1) or NOP (0111) moves to recovery. A rise with any other command pulses `illegal_o` and keeps self refresh.
- R8: On entry to recovery the wait loads `trc_cycles`, with 0 treated as 1. Each recovery edge with clock enable high counts one, and the state returns to idle on the edge that completes the count. A recovery edge with clock enable low pulses `illegal_o` and does not count. A recovery edge with clock enable high and a command other than deselect or NOP pulses `illegal_o` and still counts.
- R9: In power down with previous clock enable low, current clock enable low holds the state. A rise with deselect or NOP leaves for the state that R2 selects. A rise with any other command pulses `illegal_o` and keeps power down.
- R10: In self refresh or power down, a previous clock enable of high pulses `invalid_o` and keeps the state.
- R11: All outputs are registered and reflect the edge before. `illegal_o` and `invalid_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory interface clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Sampled clock-enable level for this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_st | input | 2 | 0 all idle, 1 row open, 2/3 burst in progress |
| trc_cycles | input | TRC_W | Recovery wait in clock-enable-high cycles |
| state_o | output | 3 | Tracked power state code |
| illegal_o | output | 1 | One-cycle pulse: illegal command for state |
| invalid_o | output | 1 | One-cycle pulse: invalid clock-enable history |
| refresh_o | output | 1 | One-cycle pulse: auto refresh seen |

## Verification
The assertions assume that `bank_st` describes the controller's bank view honestly. They also assume that `trc_cycles` is only sampled on the self-refresh exit edge, so a change at any other time is harmless. The bench drives all inputs on the falling clock edge and keeps them stable across the rising edge. It holds clock enable high through reset, which matches the reset value of the previous-level register. The directed sequences walk every state through its legal and illegal edges. A random phase biases commands toward deselect, NOP and 0001 so that the refresh, self-refresh and exit paths are hit often.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ACTIVE   = 3'd1,
    ST_ACCESS   = 3'd2,
    ST_SELF_REF = 3'd3,
    ST_SR_RECOV = 3'd4,
    ST_PWR_DOWN = 3'd5,
    ST_CLK_SUSP = 3'd6
  } pwr_state_e;

  localparam logic [1:0] BANK_IDLE = 2'd0;
  localparam logic [1:0] BANK_ROW  = 2'd1;

  // Normal operating state implied by the controller's bank status.
  function automatic pwr_state_e bank_to_state(input logic [1:0] b);
    case (b)
      2'd0:    return ST_IDLE;
      2'd1:    return ST_ACTIVE;
      default: return ST_ACCESS;
    endcase
  endfunction

endpackage

// File: rtl/cke_history.sv
module cke_history (
  input  logic clk,
  input  logic rst,
  input  logic cke,
  output logic cke_prev
);
  // Previous-edge clock-enable level; high out of reset.
  always_ff @(posedge clk) begin
    if (rst) cke_prev <= 1'b1;
    else     cke_prev <= cke;
  end
endmodule

// File: rtl/cmd_classify.sv
module cmd_classify (
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic is_desel,
  output logic is_nop,
  output logic is_refresh
);
  logic [3:0] pins;
  assign pins       = {cs_n, ras_n, cas_n, we_n};
  assign is_desel   = cs_n;
  assign is_nop     = (pins == 4'b0111);
  assign is_refresh = (pins == 4'b0001);
endmodule

// File: rtl/recovery_timer.sv
module recovery_timer #(
  parameter int TRC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TRC_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  localparam logic [TRC_W-1:0] ONE = TRC_W'(1);

  logic [TRC_W-1:0] cnt;

  // The edge that sees a count of one (or less) completes the wait.
  assign expire = tick && (cnt <= ONE);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= (load_val == '0) ? ONE : load_val;
    else if (tick && cnt > ONE) cnt <= cnt - ONE;
  end

  // R8: the count moves only on a load or a clock-enable-high tick.
  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt));

  // R8: a freshly loaded count is never zero.
  p_load_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt != '0));
endmodule

// File: rtl/sdram_pwr_tracker.sv
module sdram_pwr_tracker
  import sdram_pwr_pkg::*;
#(
  parameter int TRC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [1:0]       bank_st,
  input  logic [TRC_W-1:0] trc_cycles,
  output logic [2:0]       state_o,
  output logic             illegal_o,
  output logic             invalid_o,
  output logic             refresh_o
);

  pwr_state_e st_q, st_d;
  logic cke_prev;
  logic is_desel, is_nop, is_refresh, quiet;
  logic t_load, t_tick, t_expire;
  logic ill_d, inv_d, ref_d;
  pwr_state_e norm;

  cke_history u_hist (
    .clk     (clk),
    .rst     (rst),
    .cke     (cke),
    .cke_prev(cke_prev)
  );

  cmd_classify u_cmd (
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .is_desel  (is_desel),
    .is_nop    (is_nop),
    .is_refresh(is_refresh)
  );

  recovery_timer #(.TRC_W(TRC_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (t_load),
    .load_val(trc_cycles),
    .tick    (t_tick),
    .expire  (t_expire)
  );

  assign quiet = is_desel || is_nop;
  assign norm  = bank_to_state(bank_st);

  always_comb begin
    st_d   = st_q;
    ill_d  = 1'b0;
    inv_d  = 1'b0;
    ref_d  = 1'b0;
    t_load = 1'b0;
    t_tick = 1'b0;
    case (st_q)
      ST_IDLE, ST_ACTIVE, ST_ACCESS: begin
        if (cke_prev && !cke) begin
          if (bank_st == BANK_IDLE)
            st_d = is_refresh ? ST_SELF_REF : ST_PWR_DOWN;
          else if (bank_st == BANK_ROW)
            st_d = ST_PWR_DOWN;
          else
            st_d = ST_CLK_SUSP;
        end else begin
          st_d = norm;
          if (cke_prev && cke && bank_st == BANK_IDLE && is_refresh)
            ref_d = 1'b1;
        end
      end
      ST_SELF_REF: begin
        if (cke_prev) inv_d = 1'b1;
        else if (cke) begin
          if (quiet) begin
            st_d   = ST_SR_RECOV;
            t_load = 1'b1;
          end else begin
            ill_d = 1'b1;
          end
        end
      end
      ST_SR_RECOV: begin
        if (!cke) ill_d = 1'b1;
        else begin
          t_tick = 1'b1;
          if (!quiet) ill_d = 1'b1;
          if (t_expire) st_d = ST_IDLE;
        end
      end
      ST_PWR_DOWN: begin
        if (cke_prev) inv_d = 1'b1;
        else if (cke) begin
          if (quiet) st_d = norm;
          else       ill_d = 1'b1;
        end
      end
      ST_CLK_SUSP: begin
        if (cke) st_d = norm;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      illegal_o <= 1'b0;
      invalid_o <= 1'b0;
      refresh_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      illegal_o <= ill_d;
      invalid_o <= inv_d;
      refresh_o <= ref_d;
    end
  end

  assign state_o = st_q;

  // R1: reset leaves the tracker idle with quiet flags.
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (state_o == ST_IDLE && !illegal_o && !invalid_o && !refresh_o));

  // R3: a refresh pulse follows an idle-bank, steady-high clock-enable edge.
  p_refresh_src_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(refresh_o) |-> ($past(cke) && $past(bank_st) == BANK_IDLE));

  // R4: self refresh is only reached from idle banks.
  p_sr_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SELF_REF && $past(st_q) != ST_SELF_REF) |->
      ($past(bank_st) == BANK_IDLE && !$past(cke)));

  // R6: clock enable held low keeps clock suspend.
  p_susp_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CLK_SUSP && !cke) |=> (st_q == ST_CLK_SUSP));

  // R8: a low clock enable during recovery is flagged.
  p_recov_low_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SR_RECOV && !cke) |=> illegal_o);

  // R10: invalid history is only reported from self refresh or power down.
  p_invalid_src_r10: assert property (@(posedge clk) disable iff (rst)
    invalid_o |-> ($past(st_q) == ST_SELF_REF || $past(st_q) == ST_PWR_DOWN));

  // R11: the two error flags never coincide.
  p_flag_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(illegal_o && invalid_o));

endmodule

// File: tb/sdram_pwr_tracker_test.sv
`timescale 1ns/1ps
module sdram_pwr_tracker_test;
  localparam int TRC_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] bank_st = 2'd0;
  logic [TRC_W-1:0] trc_cycles = 8'd3;
  logic [2:0] state_o;
  logic illegal_o, invalid_o, refresh_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int m_state = 0;
  bit m_prev  = 1;
  int m_cnt   = 0;
  bit m_ill = 0, m_inv = 0, m_ref = 0;

  always #4 clk = ~clk;

  sdram_pwr_tracker #(.TRC_W(TRC_W)) uut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .bank_st(bank_st), .trc_cycles(trc_cycles),
    .state_o(state_o), .illegal_o(illegal_o), .invalid_o(invalid_o),
    .refresh_o(refresh_o)
  );

  function automatic int bank_map(input int b);
    if (b == 0) return 0;
    if (b == 1) return 1;
    return 2;
  endfunction

  task automatic model(input bit k, input logic [3:0] c, input int b);
    bit q;
    bit r;
    q = c[3] || (c == 4'b0111);
    r = (c == 4'b0001);
    m_ill = 0; m_inv = 0; m_ref = 0;
    if (m_state <= 2) begin
      if (m_prev && !k) begin
        if (b == 0)      m_state = r ? 3 : 5;
        else if (b == 1) m_state = 5;
        else             m_state = 6;
      end else begin
        m_state = bank_map(b);
        if (m_prev && k && b == 0 && r) m_ref = 1;
      end
    end else if (m_state == 3) begin
      if (m_prev) m_inv = 1;
      else if (k) begin
        if (q) begin
          m_state = 4;
          m_cnt = (trc_cycles == 0) ? 1 : int'(trc_cycles);
        end else m_ill = 1;
      end
    end else if (m_state == 4) begin
      if (!k) m_ill = 1;
      else begin
        if (!q) m_ill = 1;
        if (m_cnt <= 1) m_state = 0;
        else m_cnt--;
      end
    end else if (m_state == 5) begin
      if (m_prev) m_inv = 1;
      else if (k) begin
        if (q) m_state = bank_map(b);
        else   m_ill = 1;
      end
    end else begin
      if (k) m_state = bank_map(b);
    end
    m_prev = k;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (int'(state_o) != m_state || illegal_o != m_ill ||
        invalid_o != m_inv || refresh_o != m_ref) begin
      fails++;
      $display("FAIL %s: state/ill/inv/ref actual %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b",
               tag, state_o, illegal_o, invalid_o, refresh_o,
               m_state, m_ill, m_inv, m_ref);
    end
  endtask

  task automatic step(input bit k, input logic [3:0] c, input int b, input string tag);
    @(negedge clk);
    cke = k;
    {cs_n, ras_n, cas_n, we_n} = c;
    bank_st = 2'(b);
    model(k, c, b);
    @(posedge clk);
    #2;
    compare(tag);
  endtask

  localparam logic [3:0] DES = 4'b1111;
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] ACT = 4'b0011;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    compare("R1");                       // reset state
    // R2: normal states follow bank status
    step(1, NOP, 0, "R2");
    step(1, ACT, 1, "R2");
    step(1, NOP, 2, "R2");
    step(1, NOP, 3, "R2");
    step(1, NOP, 0, "R2");
    // R3: auto refresh pulses
    step(1, REF, 0, "R3");
    step(1, REF, 0, "R3");
    step(1, NOP, 0, "R3");
    step(1, REF, 1, "R3");               // no pulse with row open
    // R6: clock suspend
    step(1, NOP, 2, "R6");
    step(0, NOP, 2, "R6");
    step(0, NOP, 2, "R6");
    step(1, NOP, 2, "R6");
    step(1, NOP, 1, "R6");
    // R5: power down from row active, R9 exits, R10 invalid
    step(0, NOP, 1, "R5");
    step(0, NOP, 1, "R9");
    step(1, ACT, 1, "R9");               // illegal exit
    step(0, NOP, 1, "R10");              // prev high -> invalid
    step(0, NOP, 1, "R9");
    step(1, DES, 1, "R9");               // legal exit to row active
    step(1, NOP, 0, "R2");
    // R5: power down from idle with a plain command
    step(0, NOP, 0, "R5");
    step(1, NOP, 0, "R9");
    step(1, NOP, 0, "R2");
    // R4: self refresh, R7, R8 with trc=3
    trc_cycles = 8'd3;
    step(0, REF, 0, "R4");
    step(0, NOP, 0, "R7");
    step(1, REF, 0, "R7");               // illegal exit
    step(1, NOP, 0, "R10");              // invalid
    step(0, NOP, 0, "R10");              // still invalid (prev high)
    step(0, NOP, 0, "R7");
    step(1, NOP, 0, "R7");               // to recovery
    step(0, NOP, 0, "R8");               // low cke illegal, no count
    step(1, ACT, 0, "R8");               // illegal but counts
    step(1, DES, 0, "R8");
    step(1, NOP, 0, "R8");               // completes -> idle
    step(1, NOP, 0, "R8");
    // R8: trc of zero behaves as one
    trc_cycles = 8'd0;
    step(0, REF, 0, "R4");
    step(0, NOP, 0, "R7");
    step(1, DES, 0, "R7");
    step(1, NOP, 0, "R8");
    // R4: refresh command with cke falling and row open -> power down
    step(1, NOP, 1, "R4");
    step(0, REF, 1, "R4");
    step(1, NOP, 1, "R9");
    // random phase
    trc_cycles = 8'd5;
    for (int i = 0; i < 600; i++) begin
      logic [3:0] c;
      int sel;
      bit k;
      sel = $urandom_range(0, 9);
      if (sel < 3)      c = DES;
      else if (sel < 6) c = NOP;
      else if (sel < 8) c = REF;
      else              c = 4'($urandom_range(0, 15));
      k = ($urandom_range(0, 3) != 0);
      step(k, c, (i % 40 < 25) ? 0 : $urandom_range(0, 3), "R11");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule